// File: doc/BRIEF.md
# PCI Target Parity and Retry Controller

This block is the target-side control for a 32-bit PCI slave that fronts a small register space. It watches every address phase on the bus and claims memory cycles that hit a fixed window. It also claims type-0 configuration cycles whose select line is high. A claimed access completes exactly one data phase and then disconnects. Register reads and writes are passed to a simple strobe port.

Until a boot-time serial EEPROM load is reported done, every configuration cycle is answered with Retry. The block checks even parity on all address phases and on write data phases. It reports errors on the PERR# and SERR# lines. It holds two command enables and two sticky status flags, which software reaches through configuration dword 1.

Top module: `pci_tgt_ctl`

## Requirements
- R1: The block claims a memory read (C/BE# 0110) or memory write (0111) when AD[31:WIN_BITS] equals the upper bits of MEM_BASE. It claims a configuration read (1010) or write (1011) when idsel is high and AD[1:0] is 00. Every other cycle leaves DEVSEL#, TRDY# and STOP# high and has no effect on the register port.
- R2: DEVSEL# goes low in the second clock after the address phase (medium decode). TRDY# or STOP# goes low one clock after DEVSEL#.
- R3: Every claimed access ends after one data phase. STOP# is low whenever TRDY# is low. DEVSEL#, TRDY# and STOP# are released by the edge that samples IRDY# low.
- R4: A configuration cycle that arrives while load_done is low gets Retry: DEVSEL# and STOP# low, TRDY# high. Its write data has no effect on the configuration dword.
- R5: On a read, reg_rd pulses for one clock, one clock before TRDY#. AD carries the data while TRDY# is low. One clock after the data transfer, par_out is driven with the even parity of AD and C/BE#.
- R6: A memory write produces a one-clock reg_wr pulse in the clock after the transfer. The pulse carries the word address AD[WIN_BITS-1:2], the data, and active-high byte enables taken from ~C/BE#.
- R7: A write data parity error sets status bit 15 (the configuration word, bit 31). If command bit 6 is set, PERR# goes low for one clock, two clocks after the data transfer. The write still completes.
- R8: An address parity error on any address phase, claimed or not, sets status bit 15. If command bits 6 and 8 are both set, it also sets status bit 14 (word bit 30) and drives SERR# low for exactly one clock.
- R9: A configuration read of dword 1 returns {status, command}. A configuration write to dword 1 loads command bit 6 when byte enable 0 is active and command bit 8 when byte enable 1 is active. Writing 1 to word bits 31 or 30 with byte enable 3 active clears those flags. Other dwords read 0.
- R10: Reset clears the command and status bits, deasserts PERR#, SERR#, DEVSEL#, TRDY# and STOP#, and stops driving AD and PAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| ad_in | input | 32 | Address/data from the bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| par_in | input | 1 | Parity from the bus |
| ad_out | output | 32 | Read data to the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| par_out | output | 1 | Read-phase parity |
| par_oe | output | 1 | Drive enable for par_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| perr_n | output | 1 | Data parity error, active low |
| serr_n | output | 1 | System error, active low |
| load_done | input | 1 | EEPROM boot load finished |
| reg_addr | output | WIN_BITS-2 | Register word address |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Register byte enables, active high |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 32 | Register read data |

## Verification
A wrong sequencer state shows up within one or two clocks of an address phase. The handshake shifts by a clock, a disconnect is missing, or a cycle is claimed when it should not be. An error unit that misses a parity error, or sets a flag by mistake, shows up two clocks later as a wrong PERR# or SERR# pulse. It also stays visible in the status dword read afterwards. A retry that leaks its write into the command bits can only be seen on a later configuration read, so the bench reads dword 1 back after each such cycle.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
  localparam logic [5:0] CSR_DWORD  = 6'd1;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ADDR2 = 2'd1,
    S_DEVS  = 2'd2,
    S_DATA  = 2'd3
  } tgt_state_t;
endpackage

// File: rtl/pcit_parity.sv
module pcit_parity #(
  parameter int W = 36
) (
  input  logic [W-1:0] din,
  output logic         odd
);
  assign odd = ^din;
endmodule

// File: rtl/pcit_err.sv
module pcit_err (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr_phase,
  input  logic        wr_xfer,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        par_in,
  input  logic        cfg_wr,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic        perr_n,
  output logic        serr_n,
  output logic [31:0] cfg_word
);
  logic pnow, pq, apend_q, dpend_q;
  logic perr_en_q, serr_en_q, dpe_q, sse_q;
  logic aerr, derr;

  pcit_parity #(.W(36)) u_par (.din({ad_in, cbe_n}), .odd(pnow));

  assign aerr = apend_q && (pq != par_in);
  assign derr = dpend_q && (pq != par_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      pq <= 1'b0; apend_q <= 1'b0; dpend_q <= 1'b0;
      perr_en_q <= 1'b0; serr_en_q <= 1'b0;
      dpe_q <= 1'b0; sse_q <= 1'b0;
      perr_n <= 1'b1; serr_n <= 1'b1;
    end else begin
      pq      <= pnow;
      apend_q <= addr_phase;
      dpend_q <= wr_xfer;
      perr_n  <= !(derr && perr_en_q);
      serr_n  <= !(aerr && perr_en_q && serr_en_q);
      if (cfg_wr && be[0]) perr_en_q <= wdata[6];
      if (cfg_wr && be[1]) serr_en_q <= wdata[8];
      if (aerr || derr) dpe_q <= 1'b1;
      else if (cfg_wr && be[3] && wdata[31]) dpe_q <= 1'b0;
      if (aerr && perr_en_q && serr_en_q) sse_q <= 1'b1;
      else if (cfg_wr && be[3] && wdata[30]) sse_q <= 1'b0;
    end
  end

  assign cfg_word = {dpe_q, sse_q, 14'd0, 7'd0, serr_en_q, 1'b0, perr_en_q, 6'd0};

  // R7
  perr_two_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> $past(wr_xfer, 2));
  // R7
  perr_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n |=> perr_n);
  // R8
  serr_two_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> $past(addr_phase, 2));
  // R8
  serr_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_n |=> serr_n);
endmodule

// File: rtl/pcit_seq.sv
module pcit_seq
  import pcit_pkg::*;
#(
  parameter int          WIN_BITS = 12,
  parameter logic [31:0] MEM_BASE = 32'hABCDE000,
  localparam int         RA_W     = WIN_BITS - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_phase,
  input  logic            irdy_n,
  input  logic            idsel,
  input  logic [31:0]     ad_in,
  input  logic [3:0]      cbe_n,
  input  logic            load_done,
  input  logic [31:0]     reg_rdata,
  input  logic [31:0]     cfg_word,
  output logic            devsel_n,
  output logic            trdy_n,
  output logic            stop_n,
  output logic [31:0]     ad_out,
  output logic            ad_oe,
  output logic            par_out,
  output logic            par_oe,
  output logic [RA_W-1:0] reg_addr,
  output logic [31:0]     reg_wdata,
  output logic [3:0]      reg_be,
  output logic            reg_wr,
  output logic            reg_rd,
  output logic            cfg_wr,
  output logic            wr_xfer
);
  tgt_state_t st;
  logic       is_mem_q, is_wr_q, retry_q;
  logic [5:0] cfg_dw_q;
  logic       mem_hit, cfg_hit, p_rd;
  logic [31:0] rd_mux;

  pcit_parity #(.W(36)) u_rpar (.din({ad_out, cbe_n}), .odd(p_rd));

  always_comb begin
    mem_hit = ((cbe_n == CMD_MEM_RD) || (cbe_n == CMD_MEM_WR)) &&
              (ad_in[31:WIN_BITS] == MEM_BASE[31:WIN_BITS]);
    cfg_hit = idsel && ((cbe_n == CMD_CFG_RD) || (cbe_n == CMD_CFG_WR)) &&
              (ad_in[1:0] == 2'b00);
    if (is_mem_q)                rd_mux = reg_rdata;
    else if (cfg_dw_q == CSR_DWORD) rd_mux = cfg_word;
    else                         rd_mux = 32'd0;
  end

  assign wr_xfer = (st == S_DATA) && !irdy_n && !retry_q && is_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      devsel_n <= 1'b1; trdy_n <= 1'b1; stop_n <= 1'b1;
      ad_out <= 32'd0; ad_oe <= 1'b0; par_out <= 1'b0; par_oe <= 1'b0;
      reg_addr <= '0; reg_wdata <= 32'd0; reg_be <= 4'd0;
      reg_wr <= 1'b0; reg_rd <= 1'b0; cfg_wr <= 1'b0;
      is_mem_q <= 1'b0; is_wr_q <= 1'b0; retry_q <= 1'b0; cfg_dw_q <= 6'd0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      cfg_wr <= 1'b0;
      par_oe <= 1'b0;
      case (st)
        S_IDLE: begin
          if (addr_phase && (mem_hit || cfg_hit)) begin
            is_mem_q <= mem_hit;
            is_wr_q  <= cbe_n[0];
            retry_q  <= cfg_hit && !load_done;
            reg_addr <= ad_in[WIN_BITS-1:2];
            cfg_dw_q <= ad_in[7:2];
            st       <= S_ADDR2;
          end
        end
        S_ADDR2: begin
          devsel_n <= 1'b0;
          reg_rd   <= is_mem_q && !is_wr_q && !retry_q;
          st       <= S_DEVS;
        end
        S_DEVS: begin
          stop_n <= 1'b0;
          trdy_n <= retry_q;
          if (!is_wr_q && !retry_q) begin
            ad_oe  <= 1'b1;
            ad_out <= rd_mux;
          end
          st <= S_DATA;
        end
        default: begin
          if (!irdy_n) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            ad_oe    <= 1'b0;
            if (!retry_q) begin
              if (is_wr_q) begin
                reg_wdata <= ad_in;
                reg_be    <= ~cbe_n;
                reg_wr    <= is_mem_q;
                cfg_wr    <= !is_mem_q && (cfg_dw_q == CSR_DWORD);
              end else begin
                par_oe  <= 1'b1;
                par_out <= p_rd;
              end
            end
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R2
  medium_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> $past(addr_phase, 2));
  // R2
  stop_after_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_n) |-> $past(!devsel_n));
  // R3
  trdy_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !stop_n);
  // R5
  read_par_timing_chk: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> $past(!trdy_n && !irdy_n));
endmodule

// File: rtl/pci_tgt_ctl.sv
module pci_tgt_ctl #(
  parameter int          WIN_BITS = 12,
  parameter logic [31:0] MEM_BASE = 32'hABCDE000,
  localparam int         RA_W     = WIN_BITS - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            idsel,
  input  logic [31:0]     ad_in,
  input  logic [3:0]      cbe_n,
  input  logic            par_in,
  output logic [31:0]     ad_out,
  output logic            ad_oe,
  output logic            par_out,
  output logic            par_oe,
  output logic            devsel_n,
  output logic            trdy_n,
  output logic            stop_n,
  output logic            perr_n,
  output logic            serr_n,
  input  logic            load_done,
  output logic [RA_W-1:0] reg_addr,
  output logic [31:0]     reg_wdata,
  output logic [3:0]      reg_be,
  output logic            reg_wr,
  output logic            reg_rd,
  input  logic [31:0]     reg_rdata
);
  logic        frame_q, addr_phase, wr_xfer, cfg_wr;
  logic [31:0] cfg_word;

  always_ff @(posedge clk) begin
    if (rst) frame_q <= 1'b1;
    else     frame_q <= frame_n;
  end
  assign addr_phase = !frame_n && frame_q;

  pcit_seq #(.WIN_BITS(WIN_BITS), .MEM_BASE(MEM_BASE)) u_seq (
    .clk(clk), .rst(rst), .addr_phase(addr_phase), .irdy_n(irdy_n),
    .idsel(idsel), .ad_in(ad_in), .cbe_n(cbe_n), .load_done(load_done),
    .reg_rdata(reg_rdata), .cfg_word(cfg_word),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .cfg_wr(cfg_wr), .wr_xfer(wr_xfer)
  );

  pcit_err u_err (
    .clk(clk), .rst(rst), .addr_phase(addr_phase), .wr_xfer(wr_xfer),
    .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in),
    .cfg_wr(cfg_wr), .wdata(reg_wdata), .be(reg_be),
    .perr_n(perr_n), .serr_n(serr_n), .cfg_word(cfg_word)
  );
endmodule

// File: tb/pci_tgt_ctl_test.sv
module pci_tgt_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, par_in = 1'b0, load_done = 1'b0;
  logic [31:0] ad_in = 32'd0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_out, reg_wdata, reg_rdata;
  logic ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, perr_n, serr_n, reg_wr, reg_rd;
  logic [9:0] reg_addr;
  logic [3:0] reg_be;
  logic [31:0] mem [16];

  int checks = 0, errors = 0;

  // observations of the last transaction
  logic o_claim, o_serr, o_serr2, o_rd, o_trdy, o_stop, o_adoe, o_paroe, o_parout, o_wr, o_perr;
  logic [31:0] o_ad, o_wdata;
  logic [9:0]  o_waddr;
  logic [3:0]  o_be;

  // {cmd[3:0], idsel, addr[31:0], data[31:0], claim}
  localparam logic [69:0] VEC [NVEC] = '{
    {4'h7, 1'b0, 32'hABCDE010, 32'h11223344, 1'b1},
    {4'h6, 1'b0, 32'hABCDE010, 32'h11223344, 1'b1},
    {4'h7, 1'b0, 32'hABCDE7FC, 32'hA5A55A5A, 1'b1},
    {4'h6, 1'b0, 32'hABCDE7FC, 32'hA5A55A5A, 1'b1},
    {4'h7, 1'b0, 32'hABCDF010, 32'hDEADBEEF, 1'b0},
    {4'h2, 1'b0, 32'hABCDE010, 32'h00000000, 1'b0},
    {4'hA, 1'b0, 32'h00000004, 32'h00000000, 1'b0},
    {4'hB, 1'b1, 32'h00000004, 32'h00000140, 1'b1},
    {4'hA, 1'b1, 32'h00000004, 32'h00000140, 1'b1},
    {4'hA, 1'b1, 32'h00000000, 32'h00000000, 1'b1},
    {4'h6, 1'b0, 32'hABCDE010, 32'h11223344, 1'b1}
  };

  pci_tgt_ctl #(.WIN_BITS(12), .MEM_BASE(32'hABCDE000)) uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .perr_n(perr_n), .serr_n(serr_n), .load_done(load_done),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file standing behind the port
  assign reg_rdata = mem[reg_addr[3:0]];
  always @(posedge clk) if (reg_wr) mem[reg_addr[3:0]] <= reg_wdata;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [3:0] cmd, input logic ids, input logic [31:0] addr,
                     input logic [31:0] data, input logic bad_ap, input logic bad_dp);
    @(negedge clk);
    frame_n = 1'b0; idsel = ids; ad_in = addr; cbe_n = cmd; irdy_n = 1'b1;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; idsel = 1'b0;
    par_in = (^{addr, cmd}) ^ bad_ap;
    ad_in = cmd[0] ? data : 32'd0; cbe_n = 4'h0;
    @(negedge clk);
    o_claim = !devsel_n; o_serr = !serr_n; o_rd = reg_rd;
    par_in = (^{ad_in, cbe_n}) ^ bad_dp;
    @(negedge clk);
    o_trdy = !trdy_n; o_stop = !stop_n; o_ad = ad_out; o_adoe = ad_oe; o_serr2 = !serr_n;
    @(negedge clk);
    o_paroe = par_oe; o_parout = par_out; o_wr = reg_wr; o_waddr = reg_addr;
    o_wdata = reg_wdata; o_be = reg_be;
    irdy_n = 1'b1; ad_in = 32'd0; cbe_n = 4'hF;
    @(negedge clk);
    o_perr = !perr_n; par_in = 1'b0;
  endtask

  task automatic read_csr(output logic [31:0] v);
    txn(4'hA, 1'b1, 32'h4, 32'd0, 1'b0, 1'b0);
    v = o_ad;
  endtask

  task automatic write_csr(input logic [31:0] v);
    txn(4'hB, 1'b1, 32'h4, v, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(devsel_n && trdy_n && stop_n && perr_n && serr_n && !ad_oe && !par_oe,
        "R10 idle outputs", {devsel_n, trdy_n, stop_n, perr_n, serr_n, ad_oe, par_oe}, 32'h7C);

    // R4 retry before load done, write ignored
    txn(4'hB, 1'b1, 32'h4, 32'h00000140, 1'b0, 1'b0);
    chk(o_claim && o_stop && !o_trdy, "R4 retry signalling", {o_claim, o_stop, o_trdy}, 32'h6);
    chk(!o_wr, "R4 no write strobe", o_wr, 0);
    load_done = 1'b1;
    read_csr(v);
    chk(v == 32'd0, "R4 retried write had no effect", v, 0);

    // table walk: R1 R2 R3 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] c; logic ids, cl; logic [31:0] a, d;
      {c, ids, a, d, cl} = VEC[i];
      txn(c, ids, a, d, 1'b0, 1'b0);
      chk(o_claim == cl, "R1 claim decode", o_claim, cl);
      if (cl) begin
        chk(o_trdy && o_stop, "R3 single phase disconnect", {o_trdy, o_stop}, 32'h3);
        if (!c[0]) begin
          chk(o_ad == d && o_adoe, "R5/R9 read data", o_ad, d);
          chk(o_paroe && (o_parout == ^o_ad), "R5 read parity", o_parout, ^o_ad);
          if (c == 4'h6) chk(o_rd, "R5 read strobe", o_rd, 1);
        end else if (c == 4'h7) begin
          chk(o_wr && o_wdata == d && o_waddr == a[11:2] && o_be == 4'hF,
              "R6 write strobe", o_wdata, d);
        end
      end else begin
        chk(!o_trdy && !o_stop && !o_wr, "R1 unclaimed quiet", {o_trdy, o_stop, o_wr}, 0);
      end
    end

    // R7 data parity error, PERR disabled
    write_csr(32'h0);
    txn(4'h7, 1'b0, 32'hABCDE020, 32'h0BADF00D, 1'b0, 1'b1);
    chk(!o_perr, "R7 perr masked", o_perr, 0);
    chk(o_wr && o_wdata == 32'h0BADF00D, "R7 write completes", o_wdata, 32'h0BADF00D);
    read_csr(v);
    chk(v == 32'h80000000, "R7 status bit set", v, 32'h80000000);
    write_csr(32'h80000040);
    read_csr(v);
    chk(v == 32'h00000040, "R9 W1C clear and enable", v, 32'h40);
    txn(4'h7, 1'b0, 32'hABCDE020, 32'h12345678, 1'b0, 1'b1);
    chk(o_perr, "R7 perr asserted", o_perr, 1);
    read_csr(v);
    chk(v == 32'h80000040, "R7 status after perr", v, 32'h80000040);

    // R8 address parity, SERR disabled then enabled, unclaimed cycle
    write_csr(32'h80000040);
    txn(4'h7, 1'b0, 32'hABCDF000, 32'h1, 1'b1, 1'b0);
    chk(!o_serr, "R8 serr masked", o_serr, 0);
    read_csr(v);
    chk(v == 32'h80000040, "R8 status bit on unclaimed", v, 32'h80000040);
    write_csr(32'h80000140);
    txn(4'h7, 1'b0, 32'hABCDF000, 32'h1, 1'b1, 1'b0);
    chk(o_serr && !o_serr2, "R8 serr one clock", {o_serr, o_serr2}, 32'h2);
    read_csr(v);
    chk(v == 32'hC0000140, "R8 both flags", v, 32'hC0000140);
    write_csr(32'h40000100);
    read_csr(v);
    chk(v == 32'h80000100, "R9 clear bit 14 only, byte lanes", v, 32'h80000100);

    // R10 reset clears error state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk(perr_n && serr_n && devsel_n, "R10 after reset", {perr_n, serr_n, devsel_n}, 32'h7);
    read_csr(v);
    chk(v == 32'd0, "R10 status cleared", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule